// File: doc/BRIEF.md
# Bidirectional I/O Port with Per-Bit Direction

This block is a parameterized bidirectional I/O port that sits on a simple CPU register bus. It holds two registers, each at its own address. The output latch holds the value driven onto the pins. The direction register sets each pin to be either an input or a push-pull output, and software can change any bit at any time.

A read of the latch address is decided bit by bit. Input bits return the pad level, taken through a two-flop synchronizer. Output bits return the latch contents. A read-modify-write sequence therefore leaves every output bit at its stored value while it updates the others.

A static pull-up option comes in for each bit. The block turns on the pull-up only while that bit is an input.

Top module: `io_port`

## Requirements
- R1: After reset, every direction bit is 1 (input), every latch bit is 1, `pad_oe` is all 0, `pad_out` is all 1 and `rdata` is 0.
- R2: A write strobe with `addr`=0 loads `wdata` into the output latch at that clock edge. `pad_out` shows the latch from the next cycle on and holds until the next write to address 0.
- R3: A write strobe with `addr`=1 loads the direction register. A direction bit of 1 makes the pin an input (`pad_oe` bit 0). A direction bit of 0 makes it a driven output (`pad_oe` bit 1).
- R4: A read strobe with `addr`=0 captures, for each bit, the synchronized pad level when its direction bit is 1, or the latch bit when its direction bit is 0. The result is visible on `rdata` in the cycle after the strobe edge.
- R5: Pad levels pass through two flip-flops. A pad change made just before edge k is returned by a read strobed at edge k+2, and not by reads at edges k or k+1.
- R6: `pu_en` equals `pu_cfg` AND the direction bits at all times.
- R7: A read of `addr`=1 returns the direction register. A read of any other address returns 0. A write to any address other than 0 or 1 changes no register.
- R8: Reading address 0 and then writing the same value back leaves every output-bit latch value unchanged. The input-bit latch values take the pad levels that were read.
- R9: `rdata` holds its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register select: 0 latch, 1 direction |
| wdata | input | W | Write data |
| rdata | output | W | Registered read data |
| pad_in | input | W | Pin levels from the pads |
| pad_out | output | W | Output latch driven to the pads |
| pad_oe | output | W | Per-pin output-driver enable |
| pu_cfg | input | W | Static per-pin pull-up option |
| pu_en | output | W | Per-pin pull-up enable |

## Verification
The bench uses mixed-direction masks. A design that applied one direction to all bits, or that swapped the mux sense, would return the wrong nibbles. It times pad reads to the edge: a single-flop or unsynchronized path would return a new pad level one or two reads early. A read-modify-write on a port whose output latch differs from the pads would catch a design that reads pads for every bit, because it would corrupt the output latch. Reads and writes of unmapped addresses expose decoding that aliases onto the real registers.

// File: rtl/io_port.sv
module io_port #(
  parameter int W  = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  input  logic [W-1:0]  pu_cfg,
  output logic [W-1:0]  pu_en
);
  localparam logic [AW-1:0] A_LATCH = AW'(0);
  localparam logic [AW-1:0] A_DIR   = AW'(1);

  logic [W-1:0] latch_q, dir_q, sync1_q, sync2_q, port_val, rd_mux;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      latch_q <= '1;
      dir_q   <= '1;
    end else if (wr_en) begin
      if (addr == A_LATCH) latch_q <= wdata;
      if (addr == A_DIR)   dir_q   <= wdata;
    end

  assign port_val = (sync2_q & dir_q) | (latch_q & ~dir_q);

  always_comb
    case (addr)
      A_LATCH: rd_mux = port_val;
      A_DIR:   rd_mux = dir_q;
      default: rd_mux = '0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;

  assign pad_out = latch_q;
  assign pad_oe  = ~dir_q;
  assign pu_en   = pu_cfg & dir_q;
endmodule

// File: rtl/io_port_chk.sv
module io_port_chk #(
  parameter int W  = 8,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [W-1:0]  wdata,
  input logic [W-1:0]  rdata,
  input logic [W-1:0]  pad_out,
  input logic [W-1:0]  pad_oe,
  input logic [W-1:0]  pu_cfg,
  input logic [W-1:0]  pu_en
);
  p_latch_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(0)) |=> pad_out == $past(wdata));

  p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == AW'(0)) |=> $stable(pad_out));

  p_dir_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(1)) |=> pad_oe == ~$past(wdata));

  p_out_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == AW'(0)) |=> (rdata & pad_oe) == (pad_out & pad_oe));

  p_pullup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pu_en == (pu_cfg & ~pad_oe));

  p_unmapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr > AW'(1)) |=> rdata == '0);

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind io_port io_port_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .pad_out(pad_out), .pad_oe(pad_oe),
  .pu_cfg(pu_cfg), .pu_en(pu_en)
);

// File: tb/io_port_test.sv
module io_port_test;
  logic       clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, pad_in = '0, pu_cfg = 8'hF3;
  logic [7:0] rdata, pad_out, pad_oe, pu_en;
  int checks = 0, failures = 0;
  bit done = 0;

  io_port #(.W(8), .AW(2)) uut (.*);

  always #10 clk = ~clk;

  // {dir, latch, pad, expected port read}
  localparam logic [31:0] VEC [7] = '{
    32'hFF_00_A5_A5, 32'h00_3C_FF_3C, 32'hF0_5A_C3_CA, 32'h0F_96_69_99,
    32'hAA_55_FF_FF, 32'h55_00_00_00, 32'h81_7E_18_7E };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic settle_pad(logic [7:0] p);
    @(negedge clk); pad_in = p;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v, r1, r2, r3;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_out", pad_out, 8'hFF);
    chk("R1 rdata", rdata, 8'h00);
    rst_n = 1;
    rd(2'd1, v); chk("R1 dir read", v, 8'hFF);
    chk("R6 pu_en reset", pu_en, 8'hF3);

    foreach (VEC[i]) begin
      wr(2'd1, VEC[i][31:24]);
      wr(2'd0, VEC[i][23:16]);
      settle_pad(VEC[i][15:8]);
      rd(2'd0, v);
      chk("R4 per-bit read", v, VEC[i][7:0]);
      chk("R3 pad_oe", pad_oe, ~VEC[i][31:24]);
      chk("R2 pad_out", pad_out, VEC[i][23:16]);
      chk("R6 pu_en", pu_en, 8'hF3 & VEC[i][31:24]);
    end

    // R5 synchronizer latency
    wr(2'd1, 8'hFF);
    settle_pad(8'h00);
    @(negedge clk); pad_in = 8'hFF; rd_en = 1; addr = 2'd0;
    @(negedge clk); r1 = rdata;
    @(negedge clk); r2 = rdata;
    @(negedge clk); r3 = rdata; rd_en = 0;
    chk("R5 edge k", r1, 8'h00);
    chk("R5 edge k+1", r2, 8'h00);
    chk("R5 edge k+2", r3, 8'hFF);

    // R9 hold without strobe
    settle_pad(8'h12);
    repeat (2) @(negedge clk);
    chk("R9 rdata hold", rdata, 8'hFF);

    // R8 read-modify-write
    wr(2'd1, 8'h0F);
    wr(2'd0, 8'hA5);
    settle_pad(8'h3C);
    rd(2'd0, v);
    chk("R8 rmw read", v, 8'hAC);
    wr(2'd0, v);
    chk("R8 rmw latch", pad_out, 8'hAC);

    // R7 decoding
    rd(2'd1, v); chk("R7 dir read", v, 8'h0F);
    rd(2'd2, v); chk("R7 unmapped read", v, 8'h00);
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h00);
    chk("R7 unmapped write latch", pad_out, 8'hAC);
    chk("R7 unmapped write dir", pad_oe, 8'hF0);

    // R2 latch hold across direction change
    wr(2'd1, 8'h00);
    chk("R2 hold after dir write", pad_out, 8'hAC);
    rd(2'd0, v); chk("R4 all outputs", v, 8'hAC);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule